// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a multi-channel event timer. A shared free-running counter is supplied from outside. The channel holds its own comparator value, period and configuration word, and compares the counter against an armed target. When the counter reaches the target, the channel emits a one-cycle match request.

The channel runs in one-shot mode or periodic mode. In periodic mode it reloads itself by adding the period to the target. An optional 32-bit mode places the 32-bit comparator into the full counter range. In one-shot 32-bit mode, a comparator value that lies past the next 32-bit rollover produces two requests: an early one at the rollover and a second one at the target.

Software reaches the channel through 32-bit half-word writes and reads of its configuration and comparator registers. The channel also exports the configuration fields that a neighbouring router decodes:

- trigger type
- enable
- route number
- message enable

It also emits the pulses that router needs when the trigger type or the enable changes while an interrupt is pending. Interrupt status storage, routing and the counter itself live outside this block.

Top module: `evt_timer_channel`

## Requirements
- R1: After reset, the configuration low half reads 0x8030 (bit 4 periodic-capable, bit 5 wide-capable, bit 15 message-capable). The configuration high half reads the ROUTE_CAP parameter (default 0x00000A04). Both comparator halves read 0xFFFFFFFF. All routing outputs are 0.
- R2: A write to the configuration low half changes only the bits under mask 0x7F4E. Bit 1 is the trigger type (1 = level), bit 2 the enable, bit 3 periodic, bit 6 value-set, bit 8 32-bit mode, bits 13:9 the route and bit 14 message enable. Writes to the configuration high half change nothing.
- R3: A comparator write in one-shot mode updates the comparator. In periodic mode it always updates the period, and it updates the comparator only while value-set is 1. Any accepted comparator write clears value-set.
- R4: In 32-bit mode a write to the comparator high half is ignored: the comparator and value-set keep their values. A low-half write zero-extends into the comparator. Writing the configuration with bit 8 set clears the upper halves of the comparator and period.
- R5: In one-shot 64-bit mode, matchPulse is high for exactly one cycle after the edge that samples mainCount equal to the target. The channel then stays disarmed.
- R6: No match request is raised while globalEn is 0. The target is recalculated on the edge after a configuration write, an accepted comparator write, or the first edge that sees globalEn high. A match follows on the next edge if the counter already lies at or past the target.
- R7: In 32-bit mode, the target is formed from the counter's upper 32 bits joined with the comparator. If that value is below the counter, 2^32 is added to it.
- R8: In one-shot 32-bit mode, if the target lies beyond the next 32-bit counter rollover, one match request fires when the counter reaches the rollover and a second one fires at the target.
- R9: After a periodic match with a nonzero period, the period is added to the target until the target lies ahead of the counter value at that match. The comparator then reads the new target, with the upper half forced to 0 in 32-bit mode.
- R10: In periodic mode, two match requests are never closer than MIN_GAP counter values (default 100). A due match is held until the gap has passed.
- R11: A configuration write that changes bit 1 from 1 to 0 produces a one-cycle levelDropPulse after the write edge.
- R12: A configuration write that changes bit 2 from 0 to 1 while intPending and globalEn are high produces a one-cycle reassertPulse after the write edge. No pulse is produced when intPending is low.
- R13: levelMode, intEnable, routeSel and msgEnable follow configuration bits 1, 2, 13:9 and 14 from the edge that writes them.
- R14: A periodic channel with a zero period fires once at its target and then stays disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mainCount | input | 64 | Shared counter value |
| globalEn | input | 1 | Timer-wide enable |
| intPending | input | 1 | External status bit for this channel |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 configuration, 1 comparator |
| wrHi | input | 1 | Write upper 32-bit half |
| wrData | input | 32 | Write data |
| rdSel | input | 1 | Read target: 0 configuration, 1 comparator |
| rdHi | input | 1 | Read upper half |
| rdData | output | 32 | Read data (combinational) |
| matchPulse | output | 1 | One-cycle match request |
| levelDropPulse | output | 1 | Trigger type changed from level to edge |
| reassertPulse | output | 1 | Enable set while status pending |
| levelMode | output | 1 | Trigger type field |
| intEnable | output | 1 | Enable field |
| msgEnable | output | 1 | Message delivery enable field |
| routeSel | output | 5 | Route number field |

## Verification
Register contents, routing fields and the two configuration pulses change on the edge that samples the write. The armed target is rebuilt on the following edge, and a match is reported after the edge that samples the matching counter value. For that reason, every stimulus and every read in the bench happens one time unit after a rising edge. Each match is logged with the counter value that its edge sampled, so every expected match position is an exact counter value worked out from the comparator, the period and the gap rule. A periodic catch-up updates the comparator readback one or more edges after a match, so that readback is only checked once the following match is still far off.

// File: rtl/evt_chan_pkg.sv
package evt_chan_pkg;
  localparam int BIT_LEVEL    = 1;
  localparam int BIT_INTEN    = 2;
  localparam int BIT_PERIODIC = 3;
  localparam int BIT_VSET     = 6;
  localparam int BIT_MODE32   = 8;
  localparam int ROUTE_LSB    = 9;
  localparam int ROUTE_W      = 5;
  localparam int BIT_MSGEN    = 14;
  localparam logic [15:0] CFG_WMASK = 16'h7F4E;

  typedef struct packed {
    logic cmpWr;   // update comparator
    logic perWr;   // update period
    logic hiHalf;  // upper half selected
    logic fullLo;  // zero-extend low-half data (32-bit mode)
    logic trunc;   // clear upper halves of comparator and period
    logic recalc;  // rebuild the armed target now
  } dpStrobe_t;
endpackage

// File: rtl/evt_chan_ctrl.sv
module evt_chan_ctrl
  import evt_chan_pkg::*;
#(
  parameter int  BUS_W   = 32,
  parameter bit  MSG_CAP = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             globalEn,
  input  logic             intPending,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic             wrHi,
  input  logic [BUS_W-1:0] wrData,
  output logic [15:0]      cfgLo,
  output dpStrobe_t        stb,
  output logic             levelDropPulse,
  output logic             reassertPulse
);
  localparam logic [15:0] CAP_BITS = 16'h0030 | (MSG_CAP ? 16'h8000 : 16'h0000);

  logic cfgWr, cfgWrLo, cmpWrAny, cmpIgnored, cmpAccepted;
  logic enPrev, recalcQ, enRise;
  logic [15:0] cfgNext;

  assign cfgWr       = wrEn & ~wrSel;
  assign cfgWrLo     = cfgWr & ~wrHi;
  assign cmpWrAny    = wrEn & wrSel;
  assign cmpIgnored  = cmpWrAny & wrHi & cfgLo[BIT_MODE32];
  assign cmpAccepted = cmpWrAny & ~cmpIgnored;
  assign cfgNext     = (cfgLo & ~CFG_WMASK) | (wrData[15:0] & CFG_WMASK);
  assign enRise      = globalEn & ~enPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgLo          <= CAP_BITS;
      enPrev         <= 1'b0;
      recalcQ        <= 1'b0;
      levelDropPulse <= 1'b0;
      reassertPulse  <= 1'b0;
    end else begin
      if (cfgWrLo) cfgLo <= cfgNext;
      else if (cmpAccepted) cfgLo[BIT_VSET] <= 1'b0;
      enPrev         <= globalEn;
      recalcQ        <= cfgWr | cmpAccepted | enRise;
      levelDropPulse <= cfgWrLo & cfgLo[BIT_LEVEL] & ~cfgNext[BIT_LEVEL];
      reassertPulse  <= (cfgWrLo & ~cfgLo[BIT_INTEN] & cfgNext[BIT_INTEN] & intPending & globalEn)
                      | (enRise & cfgLo[BIT_INTEN] & intPending);
    end
  end

  always_comb begin
    stb        = '0;
    stb.cmpWr  = cmpAccepted & (~cfgLo[BIT_PERIODIC] | cfgLo[BIT_VSET]);
    stb.perWr  = cmpAccepted & cfgLo[BIT_PERIODIC];
    stb.hiHalf = wrHi;
    stb.fullLo = cfgLo[BIT_MODE32];
    stb.trunc  = cfgWrLo & cfgNext[BIT_MODE32];
    stb.recalc = recalcQ & globalEn;
  end

  // R4
  hi_ignore_vset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel && wrHi && cfgLo[BIT_MODE32]) |=> $stable(cfgLo[BIT_VSET]));
  // R3
  vset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel && !(wrHi && cfgLo[BIT_MODE32])) |=> !cfgLo[BIT_VSET]);
  // R11
  level_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    levelDropPulse |-> (!cfgLo[BIT_LEVEL] && $past(cfgLo[BIT_LEVEL])));
endmodule

// File: rtl/evt_chan_dp.sv
module evt_chan_dp
  import evt_chan_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int MIN_GAP = 100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               globalEn,
  input  logic [CNT_W-1:0]   mainCount,
  input  dpStrobe_t          stb,
  input  logic [CNT_W/2-1:0] wrData,
  input  logic               mode32,
  input  logic               periodic,
  output logic [CNT_W-1:0]   cmpVis,
  output logic               matchPulse
);
  localparam int HALF = CNT_W / 2;
  localparam logic [CNT_W-1:0] WRAP_STEP = {{(HALF-1){1'b0}}, 1'b1, {HALF{1'b0}}};
  localparam logic [CNT_W-1:0] LOW_ONES  = WRAP_STEP - 1'b1;
  localparam logic [CNT_W-1:0] GAP       = CNT_W'(MIN_GAP);

  logic [CNT_W-1:0] cmpReg, perReg, armTarget, fullTarget, lastMatch;
  logic armed, wrapPend, catchUp, haveLast;
  logic [CNT_W-1:0] joined, extT, nextWrap;
  logic signed [CNT_W-1:0] lagArm, leadLast;
  logic useWrap, reached, gapOk, hit, ahead;

  assign joined   = {mainCount[CNT_W-1:HALF], cmpReg[HALF-1:0]};
  assign extT     = mode32 ? ((joined < mainCount) ? joined + WRAP_STEP : joined) : cmpReg;
  assign nextWrap = (mainCount | LOW_ONES) + 1'b1;
  assign useWrap  = mode32 & ~periodic & (extT > nextWrap);
  assign lagArm   = mainCount - armTarget;
  assign leadLast = armTarget - lastMatch;
  assign reached  = (lagArm >= 0);
  assign ahead    = (leadLast > 0);
  assign gapOk    = ~periodic | ~haveLast | ((mainCount - lastMatch) >= GAP);
  assign hit      = armed & globalEn & ~catchUp & reached & gapOk;
  assign cmpVis   = cmpReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpReg     <= '1;
      perReg     <= '0;
      armTarget  <= '0;
      fullTarget <= '0;
      lastMatch  <= '0;
      armed      <= 1'b0;
      wrapPend   <= 1'b0;
      catchUp    <= 1'b0;
      haveLast   <= 1'b0;
      matchPulse <= 1'b0;
    end else begin
      matchPulse <= hit;
      // sequencing of the armed target
      if (!globalEn) begin
        armed    <= 1'b0;
        catchUp  <= 1'b0;
        wrapPend <= 1'b0;
      end else if (stb.recalc) begin
        armed    <= 1'b1;
        catchUp  <= 1'b0;
        haveLast <= 1'b0;
        if (useWrap) begin
          armTarget  <= nextWrap;
          fullTarget <= extT;
          wrapPend   <= 1'b1;
        end else begin
          armTarget  <= extT;
          wrapPend   <= 1'b0;
        end
      end else if (catchUp) begin
        if (ahead) begin
          catchUp <= 1'b0;
          cmpReg  <= mode32 ? {{HALF{1'b0}}, armTarget[HALF-1:0]} : armTarget;
        end else begin
          armTarget <= armTarget + perReg;
        end
      end else if (hit) begin
        lastMatch <= mainCount;
        haveLast  <= 1'b1;
        if (periodic && (perReg != '0)) begin
          armTarget <= armTarget + perReg;
          catchUp   <= 1'b1;
        end else if (wrapPend) begin
          wrapPend  <= 1'b0;
          armTarget <= fullTarget;
        end else begin
          armed <= 1'b0;
        end
      end
      // register writes take precedence over a catch-up readback update
      if (stb.cmpWr) begin
        if (stb.fullLo)      cmpReg <= {{HALF{1'b0}}, wrData};
        else if (stb.hiHalf) cmpReg[CNT_W-1:HALF] <= wrData;
        else                 cmpReg[HALF-1:0] <= wrData;
      end
      if (stb.perWr) begin
        if (stb.fullLo)      perReg <= {{HALF{1'b0}}, wrData};
        else if (stb.hiHalf) perReg[CNT_W-1:HALF] <= wrData;
        else                 perReg[HALF-1:0] <= wrData;
      end
      if (stb.trunc) begin
        cmpReg[CNT_W-1:HALF] <= '0;
        perReg[CNT_W-1:HALF] <= '0;
      end
    end
  end

  // R6
  no_match_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(globalEn));
  // R9
  catchup_armed_chk: assert property (@(posedge clk) disable iff (!rstN)
    catchUp |-> armed);
  // R8
  wrap_armed_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrapPend |-> armed);
endmodule

// File: rtl/evt_timer_channel.sv
module evt_timer_channel
  import evt_chan_pkg::*;
#(
  parameter int          CNT_W     = 64,
  parameter int          MIN_GAP   = 100,
  parameter bit          MSG_CAP   = 1'b1,
  parameter logic [31:0] ROUTE_CAP = 32'h0000_0A04
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] mainCount,
  input  logic             globalEn,
  input  logic             intPending,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic             wrHi,
  input  logic [31:0]      wrData,
  input  logic             rdSel,
  input  logic             rdHi,
  output logic [31:0]      rdData,
  output logic             matchPulse,
  output logic             levelDropPulse,
  output logic             reassertPulse,
  output logic             levelMode,
  output logic             intEnable,
  output logic             msgEnable,
  output logic [4:0]       routeSel
);
  localparam int HALF = CNT_W / 2;

  logic [15:0]      cfgLo;
  dpStrobe_t        stb;
  logic [CNT_W-1:0] cmpVis;

  evt_chan_ctrl #(.BUS_W(HALF), .MSG_CAP(MSG_CAP)) ctrl_i (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .intPending(intPending),
    .wrEn(wrEn), .wrSel(wrSel), .wrHi(wrHi), .wrData(wrData),
    .cfgLo(cfgLo), .stb(stb),
    .levelDropPulse(levelDropPulse), .reassertPulse(reassertPulse)
  );

  evt_chan_dp #(.CNT_W(CNT_W), .MIN_GAP(MIN_GAP)) dp_i (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .mainCount(mainCount),
    .stb(stb), .wrData(wrData), .mode32(cfgLo[BIT_MODE32]),
    .periodic(cfgLo[BIT_PERIODIC]), .cmpVis(cmpVis), .matchPulse(matchPulse)
  );

  assign levelMode = cfgLo[BIT_LEVEL];
  assign intEnable = cfgLo[BIT_INTEN];
  assign msgEnable = cfgLo[BIT_MSGEN];
  assign routeSel  = cfgLo[ROUTE_LSB +: ROUTE_W];

  always_comb begin
    if (rdSel) rdData = rdHi ? cmpVis[CNT_W-1:HALF] : cmpVis[HALF-1:0];
    else       rdData = rdHi ? ROUTE_CAP : {16'h0000, cfgLo};
  end
endmodule

// File: tb/evt_timer_channel_tb_top.sv
module evt_timer_channel_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0;
  logic [63:0] mainCount = '0;
  logic        globalEn = 1'b0, intPending = 1'b0;
  logic        wrEn = 1'b0, wrSel = 1'b0, wrHi = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdSel = 1'b0, rdHi = 1'b0;
  logic [31:0] rdData;
  logic        matchPulse, levelDropPulse, reassertPulse;
  logic        levelMode, intEnable, msgEnable;
  logic [4:0]  routeSel;

  evt_timer_channel dut_i (
    .clk(clk), .rstN(rstN), .mainCount(mainCount), .globalEn(globalEn),
    .intPending(intPending), .wrEn(wrEn), .wrSel(wrSel), .wrHi(wrHi),
    .wrData(wrData), .rdSel(rdSel), .rdHi(rdHi), .rdData(rdData),
    .matchPulse(matchPulse), .levelDropPulse(levelDropPulse),
    .reassertPulse(reassertPulse), .levelMode(levelMode),
    .intEnable(intEnable), .msgEnable(msgEnable), .routeSel(routeSel)
  );

  int nChk = 0, nBad = 0;
  logic [63:0] cnt = '0;
  logic [63:0] hits [8];
  int hitCnt = 0;
  logic [63:0] enCnt;
  logic [31:0] v;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    mainCount = cnt;
    @(posedge clk); #1;
    if (matchPulse) begin
      if (hitCnt < 8) hits[hitCnt] = cnt;
      hitCnt++;
    end
    cnt = cnt + 1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic s, input logic h, input logic [31:0] d);
    wrEn = 1'b1; wrSel = s; wrHi = h; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic s, input logic h, output logic [31:0] d);
    rdSel = s; rdHi = h; #1; d = rdData;
  endtask

  task automatic doReset();
    rstN = 1'b0; globalEn = 1'b0; intPending = 1'b0; wrEn = 1'b0;
    run(3);
    rstN = 1'b1;
    step();
    hitCnt = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    // R1 reset state
    doReset();
    rd(0, 0, v); chk("R1 cfg lo", v, 64'h8030);
    rd(0, 1, v); chk("R1 cfg hi", v, 64'h0A04);
    rd(1, 0, v); chk("R1 cmp lo", v, 64'hFFFFFFFF);
    step();
    rd(1, 1, v); chk("R1 cmp hi", v, 64'hFFFFFFFF);
    chk("R1 routing", {levelMode, intEnable, msgEnable, routeSel}, 0);
    chk("R1 no match", matchPulse, 0);

    // R2 write mask
    wr(0, 0, 32'hFFFF_FFFF);
    rd(0, 0, v); chk("R2 mask all ones", v, 64'hFF7E);
    wr(0, 1, 32'hFFFF_FFFF);
    rd(0, 1, v); chk("R2 hi read-only", v, 64'h0A04);
    wr(0, 0, 32'h0);
    rd(0, 0, v); chk("R2 mask zeros", v, 64'h8030);

    // R13 routing fields, R11 level drop
    wr(0, 0, 32'h4A06);
    chk("R13 fields", {levelMode, intEnable, msgEnable, routeSel}, {3'b111, 5'd5});
    wr(0, 0, 32'h4A04);
    chk("R11 drop pulse", levelDropPulse, 1);
    step();
    chk("R11 drop one cycle", levelDropPulse, 0);
    wr(0, 0, 32'h4A06);
    chk("R11 no pulse on set", levelDropPulse, 0);

    // R12 reassert
    doReset();
    globalEn = 1'b1; intPending = 1'b1;
    run(3);
    wr(0, 0, 32'h0004);
    chk("R12 reassert", reassertPulse, 1);
    step();
    chk("R12 one cycle", reassertPulse, 0);
    doReset();
    globalEn = 1'b1;
    run(3);
    wr(0, 0, 32'h0004);
    chk("R12 no pending", reassertPulse, 0);

    // R4 32-bit mode comparator handling
    doReset();
    wr(0, 0, 32'h0148);
    rd(1, 1, v); chk("R4 trunc hi", v, 0);
    rd(1, 0, v); chk("R4 trunc lo", v, 64'hFFFFFFFF);
    wr(1, 1, 32'h1234);
    rd(1, 1, v); chk("R4 hi ignored", v, 0);
    rd(0, 0, v); chk("R4 vset kept", v[6], 1);
    wr(1, 0, 32'h55);
    rd(1, 0, v); chk("R4 lo write", v, 64'h55);
    rd(0, 0, v); chk("R3 vset cleared", v[6], 0);

    // R5 one-shot 64-bit
    doReset(); cnt = 0;
    wr(1, 1, 0); wr(1, 0, 50);
    globalEn = 1'b1;
    run(100);
    chk("R5 single match", hitCnt, 1);
    chk("R5 match count", hits[0], 50);

    // R6 disabled then enabled past target
    doReset(); cnt = 0;
    wr(1, 1, 0); wr(1, 0, 20);
    cnt = 500;
    run(10);
    chk("R6 none while off", hitCnt, 0);
    globalEn = 1'b1; enCnt = cnt;
    run(6);
    chk("R6 one on enable", hitCnt, 1);
    chk("R6 timing", hits[0], enCnt + 2);

    // R3, R9 periodic with value-set
    doReset(); cnt = 0;
    wr(0, 0, 32'h48); wr(1, 1, 0);
    wr(0, 0, 32'h48); wr(1, 0, 200);
    wr(1, 0, 150);
    rd(1, 0, v); chk("R3 cmp kept w/o vset", v, 200);
    globalEn = 1'b1;
    run(620 - int'(cnt));
    chk("R9 count", hitCnt, 3);
    chk("R9 first", hits[0], 200);
    chk("R9 second", hits[1], 350);
    chk("R9 third", hits[2], 500);
    rd(1, 0, v); chk("R9 cmp readback", v, 650);

    // R10 minimum gap
    doReset(); cnt = 0;
    wr(0, 0, 32'h48); wr(1, 1, 0);
    wr(0, 0, 32'h48); wr(1, 0, 200);
    wr(1, 0, 40);
    globalEn = 1'b1;
    run(450 - int'(cnt));
    chk("R10 count", hitCnt, 3);
    chk("R10 first", hits[0], 200);
    chk("R10 second", hits[1], 300);
    chk("R10 third", hits[2], 400);

    // R14 zero period
    doReset(); cnt = 0;
    wr(0, 0, 32'h48); wr(1, 1, 0);
    wr(0, 0, 32'h48); wr(1, 0, 80);
    wr(1, 0, 0);
    globalEn = 1'b1;
    run(300 - int'(cnt));
    chk("R14 single", hitCnt, 1);
    chk("R14 at target", hits[0], 80);

    // R7 32-bit extension, R9 truncated readback
    doReset();
    wr(0, 0, 32'h148); wr(1, 0, 32'h20);
    cnt = 64'h3_FFFF_FFC0;
    globalEn = 1'b1;
    run(32'h70);
    chk("R7 single", hitCnt, 1);
    chk("R7 extended target", hits[0], 64'h4_0000_0020);
    rd(1, 0, v); chk("R9 trunc lo", v, 64'h40);
    rd(1, 1, v); chk("R9 trunc hi", v, 0);

    // R8 rollover event in one-shot 32-bit mode
    doReset();
    wr(0, 0, 32'h100); wr(1, 0, 32'h10);
    cnt = 64'h1_FFFF_FF00;
    globalEn = 1'b1;
    run(32'h120);
    chk("R8 two matches", hitCnt, 2);
    chk("R8 at rollover", hits[0], 64'h2_0000_0000);
    chk("R8 at target", hits[1], 64'h2_0000_0010);

    summary();
    $finish;
  end
endmodule